// File: doc/BRIEF.md
# Multicycle Add-and-Jump Processor Core

This block is a small processor core that runs two kinds of 32-bit instructions: an add, which sums two registers into a third, and an unconditional jump. Instructions come from a byte-addressed instruction memory, and each word takes four bytes. The memory is synchronous with one cycle of read latency. The core works through each instruction in five clock cycles, in this order:

1. Present the address.
2. Capture the returned word.
3. Read both source operands.
4. Form the sum.
5. Write the result and choose the next address.

The core holds 32 general registers of 32 bits each. Register 0 is tied to zero. A debug port gives direct access to the register file. It reads any register combinationally. It can also write a register, which is how a test environment loads operand values. Reset is synchronous and active high. It clears every register, sets the program counter to zero and restarts the sequence at the address phase.

Top module: `mc_add_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core resets. Afterwards `imem_addr` is 0 and every register reads 0 on the debug port.
- R2: Opcode 000001 in bits 31:26 is add. Bits 25:21 select the destination, bits 20:16 the first source and bits 15:11 the second source. The destination receives the sum of the two sources modulo 2^32.
- R3: Register 0 always reads 0. Writes to it from an add or from the debug port are discarded.
- R4: Both sources may be any registers, including the same one. When the destination equals a source, the sum uses the values held before that instruction.
- R5: After every instruction that is not a jump, the program counter advances by 4.
- R6: Opcode 000010 is jump. The next address is the top four bits of the current address, then instruction bits 25:0, then two zero bits.
- R7: Any other opcode changes no register and advances the program counter by 4.
- R8: Each instruction takes five cycles, and `imem_addr` is held for all five. The word executed is the one returned one cycle after the address was presented. The address changes only at the edge that ends write-back.
- R9: `dbg_data` shows the register selected by `dbg_sel` in the same cycle. With `dbg_we` high, `dbg_wdata` is written to that register at the next edge, provided the core is not writing back a result in that cycle.
- R10: A register changes only through an add's write-back or a debug write. Registers that no instruction targets keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word returned one cycle after its address |
| dbg_sel | input | 5 | Register selected for debug access |
| dbg_data | output | 32 | Current value of the selected register |
| dbg_we | input | 1 | Debug write strobe |
| dbg_wdata | input | 32 | Value written on a debug write |

## Verification
The assertions assume three things about the environment. Reset is applied synchronously. The memory always returns a word exactly one cycle after the address, with no stall. Debug writes never coincide with an add's write-back, so the write-port arbitration never has to drop one. The bench keeps to these conditions by parking the core on a jump-to-self loop, which never writes a register, whenever it loads registers through the debug port. It starts a program only by replacing the parked jump with a jump to the program's first word. The memory model is a registered array read, so the one-cycle latency always holds.

// File: rtl/mc_core_pkg.sv
package mc_core_pkg;

    localparam int unsigned INSN_W   = 32;
    localparam int unsigned PC_W     = 32;
    localparam int unsigned OPC_W    = 6;
    localparam int unsigned RSEL_W   = 5;
    localparam int unsigned TGT_W    = 26;
    localparam int unsigned NUM_REGS = 32;

    localparam logic [OPC_W-1:0] OPC_ADD  = 6'b000001;
    localparam logic [OPC_W-1:0] OPC_JUMP = 6'b000010;

    typedef enum logic [2:0] {
        ST_IADDR  = 3'd0,
        ST_ILATCH = 3'd1,
        ST_DECODE = 3'd2,
        ST_EXEC   = 3'd3,
        ST_WBACK  = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        K_NOP  = 2'd0,
        K_ADD  = 2'd1,
        K_JUMP = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e           kind;
        logic [RSEL_W-1:0]  rd;
        logic [RSEL_W-1:0]  rs1;
        logic [RSEL_W-1:0]  rs2;
        logic [TGT_W-1:0]   target;
    } dec_t;

endpackage

// File: rtl/mc_decode.sv
module mc_decode
    import mc_core_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);

    localparam int unsigned OPC_LSB = INSN_W - OPC_W;
    localparam int unsigned RD_LSB  = OPC_LSB - RSEL_W;
    localparam int unsigned RS1_LSB = RD_LSB - RSEL_W;
    localparam int unsigned RS2_LSB = RS1_LSB - RSEL_W;

    logic [OPC_W-1:0] opc;

    always_comb begin
        opc        = insn[INSN_W-1 -: OPC_W];
        dec.rd     = insn[RD_LSB  +: RSEL_W];
        dec.rs1    = insn[RS1_LSB +: RSEL_W];
        dec.rs2    = insn[RS2_LSB +: RSEL_W];
        dec.target = insn[TGT_W-1:0];
        unique case (opc)
            OPC_ADD:  dec.kind = K_ADD;
            OPC_JUMP: dec.kind = K_JUMP;
            default:  dec.kind = K_NOP;
        endcase
    end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned REGS   = 32,
    parameter int unsigned NRD    = 3,
    parameter int unsigned SEL_W  = $clog2(REGS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NRD-1:0][SEL_W-1:0]      rsel,
    output logic [NRD-1:0][XLEN-1:0]       rdata,
    input  logic                           we,
    input  logic [SEL_W-1:0]               wsel,
    input  logic [XLEN-1:0]                wdata
);

    localparam logic [SEL_W-1:0] ZERO_SEL = '0;

    logic [XLEN-1:0] regs_q [REGS];
    logic [XLEN-1:0] regs_d [REGS];

    always_comb begin
        regs_d = regs_q;
        if (we && (wsel != ZERO_SEL)) begin
            regs_d[wsel] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (rsel[p] == ZERO_SEL) ? '0 : regs_q[rsel[p]];
    end

endmodule

// File: rtl/mc_next_pc.sv
module mc_next_pc
    import mc_core_pkg::*;
(
    input  logic [PC_W-1:0]  pc_cur,
    input  logic             take_jump,
    input  logic [TGT_W-1:0] jump_field,
    output logic [PC_W-1:0]  pc_next
);

    localparam int unsigned KEEP_W = PC_W - TGT_W - 2;

    logic [PC_W-1:0] seq_addr;
    logic [PC_W-1:0] jmp_addr;

    always_comb begin
        seq_addr = pc_cur + PC_W'(4);
        jmp_addr = {pc_cur[PC_W-1 -: KEEP_W], jump_field, 2'b00};
        pc_next  = take_jump ? jmp_addr : seq_addr;
    end

endmodule

// File: rtl/mc_add_core.sv
module mc_add_core
    import mc_core_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    output logic [31:0]      imem_addr,
    input  logic [31:0]      imem_rdata,
    input  logic [4:0]       dbg_sel,
    output logic [XLEN-1:0]  dbg_data,
    input  logic             dbg_we,
    input  logic [XLEN-1:0]  dbg_wdata
);

    localparam int unsigned NRD   = 3;
    localparam int unsigned P_RS1 = 0;
    localparam int unsigned P_RS2 = 1;
    localparam int unsigned P_DBG = 2;

    typedef struct packed {
        seq_state_e        st;
        logic [PC_W-1:0]   pc;
        logic [INSN_W-1:0] ir;
        logic [XLEN-1:0]   opa;
        logic [XLEN-1:0]   opb;
        logic [XLEN-1:0]   sum;
    } core_t;

    core_t cur_q, cur_d;
    dec_t  dec;

    logic [PC_W-1:0]                pc_next;
    logic [NRD-1:0][RSEL_W-1:0]     rf_rsel;
    logic [NRD-1:0][XLEN-1:0]       rf_rdata;
    logic                           core_we;
    logic                           rf_we;
    logic [RSEL_W-1:0]              rf_wsel;
    logic [XLEN-1:0]                rf_wdata;
    seq_state_e                     state_now;

    mc_decode u_dec (
        .insn (cur_q.ir),
        .dec  (dec)
    );

    mc_next_pc u_npc (
        .pc_cur     (cur_q.pc),
        .take_jump  (dec.kind == K_JUMP),
        .jump_field (dec.target),
        .pc_next    (pc_next)
    );

    always_comb begin
        rf_rsel        = '0;
        rf_rsel[P_RS1] = dec.rs1;
        rf_rsel[P_RS2] = dec.rs2;
        rf_rsel[P_DBG] = dbg_sel;
        core_we  = (cur_q.st == ST_WBACK) && (dec.kind == K_ADD);
        rf_we    = core_we || dbg_we;
        rf_wsel  = core_we ? dec.rd : dbg_sel;
        rf_wdata = core_we ? cur_q.sum : dbg_wdata;
    end

    mc_regfile #(
        .XLEN  (XLEN),
        .REGS  (NUM_REGS),
        .NRD   (NRD),
        .SEL_W (RSEL_W)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .rsel  (rf_rsel),
        .rdata (rf_rdata),
        .we    (rf_we),
        .wsel  (rf_wsel),
        .wdata (rf_wdata)
    );

    always_comb begin
        cur_d = cur_q;
        unique case (cur_q.st)
            ST_IADDR: begin
                cur_d.st = ST_ILATCH;
            end
            ST_ILATCH: begin
                cur_d.ir = imem_rdata;
                cur_d.st = ST_DECODE;
            end
            ST_DECODE: begin
                cur_d.opa = rf_rdata[P_RS1];
                cur_d.opb = rf_rdata[P_RS2];
                cur_d.st  = ST_EXEC;
            end
            ST_EXEC: begin
                cur_d.sum = cur_q.opa + cur_q.opb;
                cur_d.st  = ST_WBACK;
            end
            ST_WBACK: begin
                cur_d.pc = pc_next;
                cur_d.st = ST_IADDR;
            end
            default: begin
                cur_d.st = ST_IADDR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.st  <= ST_IADDR;
            cur_q.pc  <= '0;
            cur_q.ir  <= '0;
            cur_q.opa <= '0;
            cur_q.opb <= '0;
            cur_q.sum <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign imem_addr = cur_q.pc;
    assign dbg_data  = rf_rdata[P_DBG];
    assign state_now = cur_q.st;

endmodule

// File: rtl/mc_add_core_chk.sv
module mc_add_core_chk
    import mc_core_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [31:0]       imem_addr,
    input logic [4:0]        dbg_sel,
    input logic [XLEN-1:0]   dbg_data,
    input seq_state_e        st,
    input logic [31:0]       ir,
    input logic              core_we
);

    // R1
    reset_pc_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (imem_addr == 32'h0));

    // R8
    fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(st) != ST_WBACK)) |-> $stable(imem_addr));

    // R8
    seq_order_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IADDR) |=> (st == ST_ILATCH));

    // R5
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_WBACK) && (ir[31:26] != OPC_JUMP)) |=>
            (imem_addr == $past(imem_addr) + 32'd4));

    // R6
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_WBACK) && (ir[31:26] == OPC_JUMP)) |=>
            (imem_addr == {$past(imem_addr[31:28]), $past(ir[25:0]), 2'b00}));

    // R10
    write_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        core_we |=> (st == ST_IADDR));

    // R3
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_sel == 5'd0) |-> (dbg_data == '0));

endmodule

bind mc_add_core mc_add_core_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .dbg_sel   (dbg_sel),
    .dbg_data  (dbg_data),
    .st        (state_now),
    .ir        (cur_q.ir),
    .core_we   (core_we)
);

// File: tb/tb_mc_add_core.sv
`timescale 1ns/100ps
module tb_mc_add_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr;
    logic [31:0] imem_rdata;
    logic [4:0]  dbg_sel = '0;
    logic [31:0] dbg_data;
    logic        dbg_we = 1'b0;
    logic [31:0] dbg_wdata = '0;

    logic [31:0] mem [64];
    logic [31:0] expv [32];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) imem_rdata <= mem[imem_addr[7:2]];

    mc_add_core dut (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dbg_sel(dbg_sel), .dbg_data(dbg_data), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata)
    );

    function automatic logic [31:0] enc_add(input int rd, input int a, input int b);
        return {6'b000001, 5'(rd), 5'(a), 5'(b), 11'd0};
    endfunction

    function automatic logic [31:0] enc_jmp(input logic [31:0] tgt);
        return {6'b000010, tgt[27:2]};
    endfunction

    function automatic logic [31:0] vpat(input int i);
        return 32'h1357_9BDF ^ (32'(i) * 32'h0101_0103);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_reg(input int i, output logic [31:0] v);
        dbg_sel = 5'(i);
        #1;
        v = dbg_data;
        tick();
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] ea;
        string       tag;

        // Phase A: reset state and five-cycle fetch timing with a long jump
        clear_mem();
        mem[3] = enc_jmp(32'h0800_0000);
        rst = 1'b1;
        repeat (3) tick();
        for (int i = 0; i < 32; i++) begin
            read_reg(i, v);
            check("R1 reg clear", v, 32'h0);
        end
        check("R1 pc zero", imem_addr, 32'h0);
        rst = 1'b0;
        for (int n = 1; n <= 25; n++) begin
            tick();
            ea = ((n / 5) < 4 ? 32'h0 : 32'h0800_0000) + 32'(4 * ((n / 5) % 4));
            // R8 R5 R7 R6: address held five cycles, +4 after nops, jump keeps bit 27
            check("R8/R5/R6/R7 fetch address", imem_addr, ea);
        end

        // Phase B: park on a self jump, then load registers through the debug port
        clear_mem();
        mem[0] = enc_jmp(32'h0);
        rst = 1'b1;
        repeat (2) tick();
        rst = 1'b0;
        repeat (6) tick();
        for (int i = 0; i < 32; i++) begin
            dbg_we    = 1'b1;
            dbg_sel   = 5'(i);
            dbg_wdata = (i == 0)  ? 32'hDEAD_BEEF :
                        (i == 31) ? 32'hFFFF_FFF0 :
                        (i == 30) ? 32'h0000_0025 : vpat(i);
            expv[i]   = (i == 0) ? 32'h0 : dbg_wdata;
            tick();
        end
        dbg_we = 1'b0;
        for (int i = 0; i < 32; i++) begin
            read_reg(i, v);
            tag = (i == 0) ? "R3 debug write to r0" : "R9 debug write/read";
            check(tag, v, expv[i]);
        end

        // Phase C: run a program at byte 0x40
        mem[16] = enc_add(3, 1, 2);
        mem[17] = enc_add(4, 3, 3);
        mem[18] = enc_add(5, 5, 5);
        mem[19] = enc_add(0, 1, 2);
        mem[20] = {6'h3F, 5'd6, 5'd1, 5'd2, 11'd0};
        mem[21] = enc_add(7, 31, 30);
        mem[22] = enc_add(8, 0, 9);
        mem[23] = enc_jmp(32'h0000_005C);
        expv[3] = expv[1] + expv[2];
        expv[4] = expv[3] + expv[3];
        expv[5] = expv[5] + expv[5];
        expv[7] = expv[31] + expv[30];
        expv[8] = expv[9];
        mem[0]  = enc_jmp(32'h0000_0040);
        repeat (80) tick();
        check("R6 self jump address", imem_addr, 32'h0000_005C);
        check("R2 wrap sum value", expv[7], 32'h0000_0015);
        for (int i = 0; i < 32; i++) begin
            read_reg(i, v);
            case (i)
                0:       tag = "R3 add to r0 discarded";
                3, 7:    tag = "R2 add result";
                4, 5:    tag = "R4 shared or overwritten source";
                6:       tag = "R7 unknown opcode no write";
                8:       tag = "R3 r0 as source";
                default: tag = "R10 untouched register";
            endcase
            check(tag, v, expv[i]);
        end

        // Phase D: reset after activity clears the file again
        rst = 1'b1;
        repeat (2) tick();
        for (int i = 0; i < 32; i++) begin
            read_reg(i, v);
            check("R1 clear after run", v, 32'h0);
        end
        check("R1 pc zero after run", imem_addr, 32'h0);
        rst = 1'b0;
        tick();

        finish_run();
    end

endmodule